// File: doc/BRIEF.md
# Dual-Lane Multiply-Accumulate Unit

This block holds a configurable number of identical multiply-accumulate lanes, two by default. Each lane accepts a pair of 16-bit operands on any cycle in which its valid strobe is high. It forms their product and then loads, adds or subtracts that product into a private 40-bit accumulator, or clears the accumulator. The accumulator is eight bits wider than a full product, so long sums of products run without wrapping. When a sum leaves the 40-bit signed range, it clamps to that range and a per-lane sticky flag records the event.

Per operation, a format code chooses how the two operands are read: both signed, both unsigned, or the first signed with the second unsigned. A fractional flag doubles the product, which is a one-bit left shift. Each lane always presents its accumulator in two narrower forms. The first is a 32-bit value clamped to the signed 32-bit range. The second is a 16-bit value taken from accumulator bits [31:16], optionally rounded to nearest, and clamped to the signed 16-bit range. A new accumulator value appears on the output one clock after the strobe. The two narrow results follow it without further delay.

Top module: `dual_mac`

## Requirements
- R1: While reset is low and in the cycle after it is released, every accumulator is zero, every overflow flag is low, and both extracted results read zero.
- R2: Opcode 2'b00 (load) with valid high sets the lane accumulator to the product, visible on the accumulator output one clock later.
- R3: Opcode 2'b01 adds the product to the accumulator and opcode 2'b10 subtracts it. Each result is visible one clock after the strobe.
- R4: Format 2'b00 reads both operands as signed, 2'b01 reads both as unsigned, 2'b10 reads the first operand as signed and the second as unsigned, and 2'b11 behaves as 2'b00.
- R5: With the fractional flag high, the product is doubled before it is loaded, added or subtracted.
- R6: With its valid strobe low, a lane's accumulator and overflow flag keep their values whatever its other inputs do.
- R7: A sum above 2^39-1 or below -2^39 clamps to that bound and sets the lane overflow flag. The flag stays high through later operations until a clear.
- R8: Opcode 2'b11 (clear) with valid high zeroes the accumulator and the lane overflow flag.
- R9: The 16-bit result is accumulator bits [31:16]. With the round input high, 2^15 is first added to the accumulator. With it low, the value is truncated toward minus infinity.
- R10: The 16-bit result clamps to the range -32768..32767.
- R11: The 32-bit result equals the accumulator clamped to the signed 32-bit range.
- R12: Lanes are independent: a lane's operations never change another lane's accumulator, flag or results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | LANES | Per-lane operation strobe |
| op_a | input | LANES*OP_W | First operand of each lane |
| op_b | input | LANES*OP_W | Second operand of each lane |
| opcode | input | 2*LANES | Per-lane operation: 00 load, 01 add, 10 subtract, 11 clear |
| fmt | input | 2*LANES | Per-lane operand format code |
| frac | input | LANES | Per-lane product doubling |
| rnd | input | LANES | Per-lane rounding of the 16-bit result |
| acc_out | output | LANES*ACC_W | Accumulator of each lane |
| res_h | output | LANES*OP_W | Rounded and clamped 16-bit result of each lane |
| res_w | output | LANES*2*OP_W | Clamped 32-bit result of each lane |
| ovf | output | LANES | Sticky overflow flag of each lane |

## Verification
The bench builds the block with its defaults: two lanes, 16-bit operands, 40-bit accumulators and rounding enabled. At these widths the largest product, unsigned and doubled, is just under 2^33, so about 65 consecutive additions carry a lane past 2^39-1. A run of 70 subtractions carries it below -2^39. Both clamps and the sticky flag therefore fall inside a short run, and the other lane can be watched for disturbance the whole time. The 16-bit operands also let single loads place values on either side of every 16-bit and 32-bit clamp boundary, and on the exact half-step where rounding matters.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

   typedef enum logic [1:0] {
      MAC_LOAD = 2'b00,
      MAC_ADD  = 2'b01,
      MAC_SUB  = 2'b10,
      MAC_CLR  = 2'b11
   } mac_op_e;

   typedef enum logic [1:0] {
      FMT_SS  = 2'b00,
      FMT_UU  = 2'b01,
      FMT_SU  = 2'b10,
      FMT_SS2 = 2'b11
   } mac_fmt_e;

endpackage

// File: rtl/dmac_mul.sv
module dmac_mul
   import dmac_pkg::*;
#(
   parameter int OP_W = 16,
   localparam int PW  = 2*OP_W + 3
) (
   input  logic [OP_W-1:0]       a,
   input  logic [OP_W-1:0]       b,
   input  logic [1:0]            fmt,
   input  logic                  frac,
   output logic signed [PW-1:0]  prod
);
   localparam int RAW_W = 2*OP_W + 2;

   logic                    a_sx;
   logic                    b_sx;
   logic signed [OP_W:0]    a_e;
   logic signed [OP_W:0]    b_e;
   logic signed [RAW_W-1:0] raw;

   // R4: first operand is unsigned only in the all-unsigned format,
   // second operand is signed only in the two all-signed codes
   assign a_sx = (fmt != FMT_UU);
   assign b_sx = (fmt == FMT_SS) || (fmt == FMT_SS2);

   assign a_e = {a_sx & a[OP_W-1], a};
   assign b_e = {b_sx & b[OP_W-1], b};
   assign raw = a_e * b_e;

   // R5: fractional doubling is a one-bit left shift
   assign prod = frac ? {raw, 1'b0} : {raw[RAW_W-1], raw};

endmodule

// File: rtl/dmac_acc.sv
module dmac_acc
   import dmac_pkg::*;
#(
   parameter int ACC_W = 40,
   parameter int PW    = 35
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    valid,
   input  logic [1:0]              op,
   input  logic signed [PW-1:0]    prod,
   output logic signed [ACC_W-1:0] acc,
   output logic                    ovf
);
   localparam int SW = ACC_W + 2;
   localparam logic signed [SW-1:0] MAXV = {3'b000, {(ACC_W-1){1'b1}}};
   localparam logic signed [SW-1:0] MINV = {3'b111, {(ACC_W-1){1'b0}}};

   logic signed [SW-1:0]    acc_x;
   logic signed [SW-1:0]    prod_x;
   logic signed [SW-1:0]    sum;
   logic                    hi;
   logic                    lo;
   logic signed [ACC_W-1:0] nxt;

   assign acc_x  = {{2{acc[ACC_W-1]}}, acc};
   assign prod_x = {{(SW-PW){prod[PW-1]}}, prod};

   always_comb begin
      unique case (op)
         MAC_LOAD: sum = prod_x;
         MAC_ADD:  sum = acc_x + prod_x;
         MAC_SUB:  sum = acc_x - prod_x;
         default:  sum = '0;
      endcase
   end

   // R7: clamp to the accumulator range
   assign hi  = (sum > MAXV);
   assign lo  = (sum < MINV);
   assign nxt = hi ? MAXV[ACC_W-1:0] : (lo ? MINV[ACC_W-1:0] : sum[ACC_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0;
         ovf <= 1'b0;
      end else if (valid) begin
         if (op == MAC_CLR) begin
            acc <= '0;
            ovf <= 1'b0;
         end else begin
            acc <= nxt;
            ovf <= ovf | hi | lo;
         end
      end
   end

endmodule

// File: rtl/dmac_extract.sv
module dmac_extract #(
   parameter int ACC_W    = 40,
   parameter int OP_W     = 16,
   parameter bit ROUND_EN = 1'b1,
   localparam int RW      = 2*OP_W
) (
   input  logic signed [ACC_W-1:0] acc,
   input  logic                    rnd,
   output logic [OP_W-1:0]         res_h,
   output logic [RW-1:0]           res_w
);
   localparam int EW = ACC_W + 1;
   localparam int HW = EW - OP_W;
   localparam logic [EW-1:0] ROUND_K =
      {{(EW-OP_W){1'b0}}, 1'b1, {(OP_W-1){1'b0}}};
   localparam logic signed [HW-1:0] H_MAX = {{(HW-OP_W+1){1'b0}}, {(OP_W-1){1'b1}}};
   localparam logic signed [HW-1:0] H_MIN = {{(HW-OP_W+1){1'b1}}, {(OP_W-1){1'b0}}};
   localparam logic signed [ACC_W-1:0] W_MAX = {{(ACC_W-RW+1){1'b0}}, {(RW-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] W_MIN = {{(ACC_W-RW+1){1'b1}}, {(RW-1){1'b0}}};

   logic [EW-1:0]        add_k;
   logic [EW-1:0]        rnd_sum;
   logic signed [HW-1:0] hi_part;

   generate
      if (ROUND_EN) begin : g_round
         assign add_k = rnd ? ROUND_K : '0;
      end else begin : g_trunc
         logic unused_rnd;
         assign unused_rnd = rnd;
         assign add_k = '0;
      end
   endgenerate

   // R9: optional half-step bias, then keep bits above the low OP_W
   assign rnd_sum = {acc[ACC_W-1], acc} + add_k;
   assign hi_part = rnd_sum[EW-1:OP_W];

   // R10: narrow result clamp
   assign res_h = (hi_part > H_MAX) ? H_MAX[OP_W-1:0] :
                  (hi_part < H_MIN) ? H_MIN[OP_W-1:0] : hi_part[OP_W-1:0];

   // R11: wide result clamp
   assign res_w = (acc > W_MAX) ? W_MAX[RW-1:0] :
                  (acc < W_MIN) ? W_MIN[RW-1:0] : acc[RW-1:0];

endmodule

// File: rtl/dual_mac.sv
module dual_mac #(
   parameter int LANES    = 2,
   parameter int OP_W     = 16,
   parameter int ACC_W    = 40,
   parameter bit ROUND_EN = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [LANES-1:0]          in_valid,
   input  logic [LANES*OP_W-1:0]     op_a,
   input  logic [LANES*OP_W-1:0]     op_b,
   input  logic [2*LANES-1:0]        opcode,
   input  logic [2*LANES-1:0]        fmt,
   input  logic [LANES-1:0]          frac,
   input  logic [LANES-1:0]          rnd,
   output logic [LANES*ACC_W-1:0]    acc_out,
   output logic [LANES*OP_W-1:0]     res_h,
   output logic [LANES*2*OP_W-1:0]   res_w,
   output logic [LANES-1:0]          ovf
);
   localparam int PW = 2*OP_W + 3;
   localparam int RW = 2*OP_W;

   if (LANES < 1) begin : g_bad_lanes
      $error("dual_mac: LANES must be at least 1");
   end
   if (OP_W < 2) begin : g_bad_opw
      $error("dual_mac: OP_W must be at least 2");
   end
   if (ACC_W < 2*OP_W + 2) begin : g_bad_accw
      $error("dual_mac: ACC_W must leave guard bits above a doubled product");
   end

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         logic signed [PW-1:0]    prod;
         logic signed [ACC_W-1:0] acc;
         logic                    flag;

         dmac_mul #(.OP_W(OP_W)) u_mul (
            .a    (op_a[i*OP_W +: OP_W]),
            .b    (op_b[i*OP_W +: OP_W]),
            .fmt  (fmt[2*i +: 2]),
            .frac (frac[i]),
            .prod (prod)
         );

         dmac_acc #(.ACC_W(ACC_W), .PW(PW)) u_acc (
            .clk   (clk),
            .rst_n (rst_n),
            .valid (in_valid[i]),
            .op    (opcode[2*i +: 2]),
            .prod  (prod),
            .acc   (acc),
            .ovf   (flag)
         );

         dmac_extract #(.ACC_W(ACC_W), .OP_W(OP_W), .ROUND_EN(ROUND_EN)) u_ext (
            .acc   (acc),
            .rnd   (rnd[i]),
            .res_h (res_h[i*OP_W +: OP_W]),
            .res_w (res_w[i*RW +: RW])
         );

         assign acc_out[i*ACC_W +: ACC_W] = acc;
         assign ovf[i] = flag;
      end
   endgenerate

endmodule

// File: rtl/dual_mac_chk.sv
module dual_mac_chk #(
   parameter int LANES = 2,
   parameter int OP_W  = 16,
   parameter int ACC_W = 40
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [LANES-1:0]        in_valid,
   input logic [2*LANES-1:0]      opcode,
   input logic [LANES*ACC_W-1:0]  acc_out,
   input logic [LANES*2*OP_W-1:0] res_w,
   input logic [LANES-1:0]        ovf
);
   localparam int RW = 2*OP_W;
   localparam logic signed [ACC_W-1:0] A_MAX = {1'b0, {(ACC_W-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] A_MIN = {1'b1, {(ACC_W-1){1'b0}}};
   localparam logic signed [ACC_W-1:0] W_MAX = {{(ACC_W-RW+1){1'b0}}, {(RW-1){1'b1}}};

   for (genvar i = 0; i < LANES; i++) begin : g_chk
      logic signed [ACC_W-1:0] a_l;
      logic                    clr_l;
      assign a_l   = acc_out[i*ACC_W +: ACC_W];
      assign clr_l = in_valid[i] && (opcode[2*i +: 2] == 2'b11);

      assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid[i] |=> ($stable(acc_out[i*ACC_W +: ACC_W]) && $stable(ovf[i])));

      assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
         clr_l |=> (a_l == '0 && !ovf[i]));

      assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (ovf[i] && !clr_l) |=> ovf[i]);

      assert_clamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ovf[i]) |-> (a_l == A_MAX || a_l == A_MIN));

      assert_wide_sat_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (a_l > W_MAX) |-> (res_w[i*RW +: RW] == W_MAX[RW-1:0]));
   end

endmodule

bind dual_mac dual_mac_chk #(
   .LANES (LANES),
   .OP_W  (OP_W),
   .ACC_W (ACC_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .opcode   (opcode),
   .acc_out  (acc_out),
   .res_w    (res_w),
   .ovf      (ovf)
);

// File: tb/sim_dual_mac.sv
module sim_dual_mac;
   localparam int LANES = 2;
   localparam int OP_W  = 16;
   localparam int ACC_W = 40;

   logic                     clk = 1'b0;
   logic                     rst_n = 1'b0;
   logic [LANES-1:0]         in_valid = '0;
   logic [LANES*OP_W-1:0]    op_a = '0;
   logic [LANES*OP_W-1:0]    op_b = '0;
   logic [2*LANES-1:0]       opcode = '0;
   logic [2*LANES-1:0]       fmt = '0;
   logic [LANES-1:0]         frac = '0;
   logic [LANES-1:0]         rnd = '0;
   logic [LANES*ACC_W-1:0]   acc_out;
   logic [LANES*OP_W-1:0]    res_h;
   logic [LANES*2*OP_W-1:0]  res_w;
   logic [LANES-1:0]         ovf;

   int n_cmp = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   dual_mac #(.LANES(LANES), .OP_W(OP_W), .ACC_W(ACC_W)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
      .opcode(opcode), .fmt(fmt), .frac(frac), .rnd(rnd),
      .acc_out(acc_out), .res_h(res_h), .res_w(res_w), .ovf(ovf)
   );

   typedef struct packed {
      logic [1:0]         op;
      logic [1:0]         fm;
      logic               fr;
      logic [15:0]        a;
      logic [15:0]        b;
      logic signed [39:0] ex;
   } vec_t;

   localparam vec_t VT [9] = '{
      '{2'b00, 2'b00, 1'b0, 16'h0003, 16'hFFFC, -40'sd12},          // R2 signed load
      '{2'b01, 2'b00, 1'b0, 16'hFF9C, 16'hFF38,  40'sd19988},       // R3 add
      '{2'b10, 2'b00, 1'b0, 16'h03E8, 16'h001E, -40'sd10012},       // R3 subtract
      '{2'b00, 2'b01, 1'b0, 16'hFFFF, 16'hFFFF,  40'sd4294836225},  // R4 unsigned
      '{2'b01, 2'b10, 1'b0, 16'hFFFF, 16'hFFFF,  40'sd4294770690},  // R4 mixed
      '{2'b00, 2'b11, 1'b0, 16'hFFFF, 16'hFFFF,  40'sd1},           // R4 code 11
      '{2'b00, 2'b00, 1'b1, 16'h4000, 16'h4000,  40'sd536870912},   // R5 doubled
      '{2'b10, 2'b00, 1'b1, 16'h8000, 16'h8000, -40'sd1610612736},  // R5 doubled sub
      '{2'b11, 2'b00, 1'b0, 16'h1234, 16'h5678,  40'sd0}            // R8 clear
   };

   function automatic longint acc_of(int ln);
      logic signed [ACC_W-1:0] v;
      v = acc_out[ln*ACC_W +: ACC_W];
      return longint'(v);
   endfunction

   function automatic longint resh_of(int ln);
      logic signed [OP_W-1:0] v;
      v = res_h[ln*OP_W +: OP_W];
      return longint'(v);
   endfunction

   function automatic longint resw_of(int ln);
      logic signed [2*OP_W-1:0] v;
      v = res_w[ln*2*OP_W +: 2*OP_W];
      return longint'(v);
   endfunction

   task automatic chk(string tag, longint act, longint exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic put(int ln, logic [1:0] op, logic [1:0] fm, logic fr,
                      logic [15:0] a, logic [15:0] b, logic v);
      in_valid[ln]         = v;
      opcode[ln*2 +: 2]    = op;
      fmt[ln*2 +: 2]       = fm;
      frac[ln]             = fr;
      op_a[ln*OP_W +: OP_W] = a;
      op_b[ln*OP_W +: OP_W] = b;
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
      in_valid = '0;
   endtask

   localparam longint AMAX = 64'sd549755813887;
   localparam longint AMIN = -64'sd549755813888;
   localparam longint PBIG = 64'sd8589672450;

   task automatic sat_run(bit up);
      longint m;
      put(1, 2'b11, 2'b00, 1'b0, 16'h0, 16'h0, 1'b1);
      tick();
      m = 0;
      for (int k = 0; k < 70; k++) begin
         put(1, up ? 2'b01 : 2'b10, 2'b01, 1'b1, 16'hFFFF, 16'hFFFF, 1'b1);
         tick();
         m = up ? m + PBIG : m - PBIG;
         if (m > AMAX) m = AMAX;
         if (m < AMIN) m = AMIN;
         chk("R7 clamp run acc", acc_of(1), m);
      end
      chk("R7 overflow flag set", longint'(ovf[1]), 1);
      chk("R12 lane0 untouched by lane1", acc_of(0), -64'sd4294901760);
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 acc0 in reset", acc_of(0), 0);
      chk("R1 ovf in reset", longint'(ovf), 0);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk("R1 acc0 after reset", acc_of(0), 0);
      chk("R1 acc1 after reset", acc_of(1), 0);
      chk("R1 res_h after reset", longint'(res_h), 0);
      chk("R1 res_w after reset", longint'(res_w), 0);

      // R2 R3 R4 R5 R8 vector walk on lane 0, lane 1 idle
      for (int i = 0; i < 9; i++) begin
         put(0, VT[i].op, VT[i].fm, VT[i].fr, VT[i].a, VT[i].b, 1'b1);
         put(1, 2'b00, 2'b00, 1'b1, 16'h7FFF, 16'h7FFF, 1'b0);
         tick();
         chk($sformatf("R2/R3/R4/R5/R8 vector %0d", i), acc_of(0), longint'(VT[i].ex));
         chk("R12 lane1 idle", acc_of(1), 0);
         chk("R6 lane1 flag idle", longint'(ovf[1]), 0);
      end

      // R6: strobe low ignores other inputs
      put(0, 2'b00, 2'b00, 1'b0, 16'd5, 16'd5, 1'b1);
      tick();
      chk("R2 load 25", acc_of(0), 25);
      put(0, 2'b00, 2'b00, 1'b0, 16'd9, 16'd9, 1'b0);
      tick();
      chk("R6 hold without strobe", acc_of(0), 25);

      // R9 rounding
      put(0, 2'b00, 2'b01, 1'b0, 16'd3, 16'h8000, 1'b1);
      tick();
      rnd[0] = 1'b0; #1;
      chk("R9 truncate +1.5", resh_of(0), 1);
      rnd[0] = 1'b1; #1;
      chk("R9 round +1.5", resh_of(0), 2);
      put(0, 2'b00, 2'b00, 1'b0, 16'd3, 16'h8000, 1'b1);
      tick();
      rnd[0] = 1'b0; #1;
      chk("R9 truncate -1.5", resh_of(0), -2);
      rnd[0] = 1'b1; #1;
      chk("R9 round -1.5", resh_of(0), -1);

      // R10 R11 clamps
      rnd[0] = 1'b0;
      put(0, 2'b00, 2'b01, 1'b0, 16'hFFFF, 16'hFFFF, 1'b1);
      tick();
      chk("R10 res_h upper clamp", resh_of(0), 32767);
      chk("R11 res_w upper clamp", resw_of(0), 2147483647);
      put(0, 2'b00, 2'b10, 1'b0, 16'h8000, 16'hFFFF, 1'b1);
      tick();
      chk("R11 res_w in range", resw_of(0), -64'sd2147450880);
      chk("R10 res_h lower clamp", resh_of(0), -32768);
      rnd[0] = 1'b1; #1;
      chk("R9 round near lower edge", resh_of(0), -32767);
      rnd[0] = 1'b0;
      put(0, 2'b00, 2'b10, 1'b1, 16'h8000, 16'hFFFF, 1'b1);
      tick();
      chk("R5 doubled mixed load", acc_of(0), -64'sd4294901760);
      chk("R11 res_w lower clamp", resw_of(0), -64'sd2147483648);
      chk("R10 res_h lower clamp wide", resh_of(0), -32768);

      // R7 positive clamp, sticky flag, R8 clear
      sat_run(1'b1);
      put(1, 2'b10, 2'b01, 1'b1, 16'hFFFF, 16'hFFFF, 1'b1);
      tick();
      chk("R7 leave bound", acc_of(1), AMAX - PBIG);
      chk("R7 flag sticky", longint'(ovf[1]), 1);
      put(1, 2'b11, 2'b00, 1'b0, 16'h0, 16'h0, 1'b1);
      tick();
      chk("R8 clear acc", acc_of(1), 0);
      chk("R8 clear flag", longint'(ovf[1]), 0);

      // R7 negative clamp
      sat_run(1'b0);
      chk("R7 lower bound", acc_of(1), AMIN);
      chk("R12 lane0 flag clear", longint'(ovf[0]), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule